// File: doc/BRIEF.md
# Register-List Multiple Transfer Sequencer

This block carries out the load-multiple and store-multiple operations. Each one moves a group of general registers between the register file and the stack, which R15 addresses. A request gives an 8-bit opcode and an 8-bit selection bitmap. The opcode picks the direction and one of the two halves of the register file: R0–R7 or R8–R15. Bit i of the bitmap selects register i of that half. A set of registers that spans both halves takes two requests, one for each half.

Once a request is accepted, the sequencer issues one word-wide memory request for each selected register on a valid/ready interface. Stores read the register file, and loads write it. After every transfer the block reports the new stack-pointer value. Stores pre-decrement the pointer and loads post-increment it. Stores visit registers from high to low and loads from low to high, so a load of a given list restores exactly what a store of the same list saved. A single-cycle `done` pulse marks the end of each operation.

Top module: `regmov_seq`

## Requirements
- R1: A start is accepted only when the block is idle and the opcode is one of these four: 0x8C (load, registers 0–7), 0x8D (load, registers 8–15), 0x8E (store, registers 0–7), 0x8F (store, registers 8–15). Any other opcode produces no memory request, no `busy` and no `done`.
- R2: Exactly one memory request is issued for each set bit of the list. Each completed transfer moves the stack pointer by 4 bytes.
- R3: On a load, each transfer reads the word at the current stack pointer and writes it to register 8*bank+i. The stack pointer is then reported as that address plus 4.
- R4: On a store, the stack pointer is first lowered by 4. Register 8*bank+i is then written to that new address, and the new address is reported as the stack pointer.
- R5: Loads visit the set bits from bit 0 upward. Stores visit them from bit 7 downward.
- R6: An accepted empty list raises `done` in the next cycle, issues no memory request and does not write the stack pointer.
- R7: A request waits for `mem_ready`. While `mem_valid` is high and `mem_ready` is low, the request stays up with unchanged address, direction and register selection.
- R8: `busy` is high from the cycle after an accepted non-empty start until the last handshake. `done` is high for exactly the one cycle after that handshake.
- R9: A start that arrives while `busy` is high is ignored.
- R10: When R15 appears in a load list, the loaded word is written to R15 and the stack-pointer write for that transfer is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse |
| opcode | input | 8 | Operation code |
| reglist | input | 8 | Register selection bitmap |
| sp_in | input | 32 | Current R15 value, sampled at start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Byte address of word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 32 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| sp_we | output | 1 | Stack-pointer write enable |
| sp_wdata | output | 32 | New stack-pointer value |

## Verification
The bench runs sparse lists (0xA5), full lists (0xFF), a list holding only R15, a list without R15, and an empty list, on both banks. This separates errors in the visiting order, in the bank offset and in the pre- and post-adjustment of the stack pointer. A store followed by a load of the same list after the registers are cleared checks the restore property. A memory-ready pattern with stalls checks that requests are held. An illegal opcode and a start issued mid-operation check that such starts are rejected.

// File: rtl/regmov_pkg.sv
package regmov_pkg;
  localparam int ADDR_W     = 32;
  localparam int WORD_BYTES = 4;

  typedef enum logic {ST_IDLE, ST_XFER} st_e;

  // opcodes 0x8C..0x8F: bit1 = store, bit0 = upper bank
  function automatic logic op_legal(input logic [7:0] op);
    return op[7:2] == 6'b100011;
  endfunction

  function automatic logic op_store(input logic [7:0] op);
    return op[1];
  endfunction

  function automatic logic op_bank(input logic [7:0] op);
    return op[0];
  endfunction

  // one word step of the stack pointer
  function automatic logic [ADDR_W-1:0] sp_after(input logic [ADDR_W-1:0] sp,
                                                 input logic store);
    return store ? sp - ADDR_W'(WORD_BYTES) : sp + ADDR_W'(WORD_BYTES);
  endfunction

  // address a transfer uses given the stack pointer before it
  function automatic logic [ADDR_W-1:0] xfer_addr(input logic [ADDR_W-1:0] sp,
                                                  input logic store);
    return store ? sp - ADDR_W'(WORD_BYTES) : sp;
  endfunction
endpackage

// File: rtl/regmov_pick.sv
module regmov_pick #(
  parameter int LIST_W = 8,
  localparam int IW = $clog2(LIST_W)
) (
  input  logic [LIST_W-1:0] mask,
  input  logic              descend,
  output logic [IW-1:0]     idx,
  output logic              any
);
  logic [LIST_W-1:0] rev;
  logic [LIST_W-1:0] ord;
  logic [IW-1:0]     pos;

  for (genvar g = 0; g < LIST_W; g++) begin : g_rev
    assign rev[g] = mask[LIST_W-1-g];
  end

  assign ord = descend ? rev : mask;

  always_comb begin
    pos = '0;
    for (int i = LIST_W - 1; i >= 0; i--) begin
      if (ord[i]) pos = IW'(i);
    end
  end

  assign idx = descend ? IW'(LIST_W - 1) - pos : pos;
  assign any = |mask;

  // R5: the chosen position is always a pending bit
  always_comb begin
    if (any) begin
      assert_pick_set_R5: assert (mask[idx]);
    end
  end
endmodule

// File: rtl/regmov_ctrl.sv
module regmov_ctrl
  import regmov_pkg::*;
#(
  parameter int LIST_W = 8,
  localparam int IW = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [LIST_W-1:0] reglist,
  input  logic              fire,
  input  logic [IW-1:0]     idx,
  output logic              accept,
  output logic              busy,
  output logic              store_q,
  output logic              bank_q,
  output logic [LIST_W-1:0] mask_q,
  output logic              done
);
  st_e               state;
  logic [LIST_W-1:0] clear;
  logic [LIST_W-1:0] mask_left;
  logic              last_fire;

  assign busy      = (state == ST_XFER);
  assign accept    = start && !busy && op_legal(opcode);
  assign clear     = fire ? (LIST_W'(1) << idx) : '0;
  assign mask_left = mask_q & ~clear;
  assign last_fire = fire && (mask_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      mask_q  <= '0;
      store_q <= 1'b0;
      bank_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          store_q <= op_store(opcode);
          bank_q  <= op_bank(opcode);
          mask_q  <= reglist;
          if (reglist == '0) done  <= 1'b1;
          else               state <= ST_XFER;
        end
        ST_XFER: if (fire) begin
          mask_q <= mask_left;
          if (last_fire) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_empty_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (reglist == '0) |=> done && !busy);
  assert_busy_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (mask_q != '0));
  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_fire |=> done && !busy);
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !fire |=> busy && $stable(mask_q) && $stable(store_q) && $stable(bank_q));
endmodule

// File: rtl/regmov_sp.sv
module regmov_sp
  import regmov_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic              store,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] next
);
  logic [ADDR_W-1:0] sp_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    sp_q <= '0;
    else if (load) sp_q <= sp_in;
    else if (step) sp_q <= next;
  end

  assign addr = xfer_addr(sp_q, store);
  assign next = sp_after(sp_q, store);

  assert_sp_stride_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step && !load |=> (sp_q == $past(sp_q) + ADDR_W'(WORD_BYTES)) ||
                      (sp_q == $past(sp_q) - ADDR_W'(WORD_BYTES)));
endmodule

// File: rtl/regmov_seq.sv
module regmov_seq
  import regmov_pkg::*;
#(
  parameter int LIST_W = 8,
  parameter int DATA_W = 32,
  localparam int IW    = $clog2(LIST_W),
  localparam int RIX_W = IW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        opcode,
  input  logic [LIST_W-1:0] reglist,
  input  logic [ADDR_W-1:0] sp_in,
  output logic              busy,
  output logic              done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [RIX_W-1:0]  rf_raddr,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_we,
  output logic [RIX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_wdata
);
  // named internal events
  logic              accept;
  logic              fire;
  logic              store_q;
  logic              bank_q;
  logic [LIST_W-1:0] mask_q;
  logic [IW-1:0]     idx;
  logic              any;
  logic [RIX_W-1:0]  cur_reg;
  logic              sp_reg_hit;
  logic [ADDR_W-1:0] sp_next;

  regmov_ctrl #(.LIST_W(LIST_W)) u_ctrl (
    .clk, .rst_n, .start, .opcode, .reglist,
    .fire, .idx, .accept, .busy, .store_q, .bank_q, .mask_q, .done
  );

  regmov_pick #(.LIST_W(LIST_W)) u_pick (
    .mask(mask_q), .descend(store_q), .idx, .any
  );

  regmov_sp u_sp (
    .clk, .rst_n, .load(accept), .sp_in, .store(store_q),
    .step(fire), .addr(mem_addr), .next(sp_next)
  );

  assign fire       = mem_valid && mem_ready;
  assign cur_reg    = {bank_q, idx};
  assign sp_reg_hit = (cur_reg == {RIX_W{1'b1}});

  assign mem_valid = busy && any;
  assign mem_write = store_q;
  assign rf_raddr  = cur_reg;
  assign mem_wdata = rf_rdata;
  assign rf_we     = fire && !store_q;
  assign rf_waddr  = cur_reg;
  assign rf_wdata  = mem_rdata;
  assign sp_we     = fire && !(!store_q && sp_reg_hit);
  assign sp_wdata  = sp_next;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                $stable(mem_write) && $stable(rf_raddr));
  assert_store_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we && mem_write |-> sp_wdata == mem_addr);
  assert_load_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we && !mem_write |-> sp_wdata == mem_addr + ADDR_W'(WORD_BYTES));
  assert_sp_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && (rf_waddr == {RIX_W{1'b1}}) |-> !sp_we);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_valid && !sp_we && !rf_we);
endmodule

// File: tb/regmov_seq_tb.sv
module regmov_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  reglist = '0;
  logic [31:0] sp_in;
  logic        busy, done, mem_valid, mem_write, rf_we, sp_we;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, sp_wdata;
  logic [3:0]  rf_raddr, rf_waddr;

  logic [31:0] regs [16];
  logic [31:0] mem  [64];

  typedef struct {
    bit          wr;
    logic [31:0] addr;
    logic [31:0] data;
    logic [3:0]  r;
  } item_t;
  item_t q[$];

  int checks = 0;
  int errors = 0;
  bit stall = 0;
  bit exp_done = 0;
  bit empty_expect = 0;
  bit was_stalled = 0;
  logic [31:0] stall_addr;
  int cyc = 0;

  always #4 clk = ~clk;

  assign sp_in     = regs[15];
  assign rf_rdata  = regs[rf_raddr];
  assign mem_rdata = mem[mem_addr[7:2]];

  regmov_seq u_dut (
    .clk, .rst_n, .start, .opcode, .reglist, .sp_in, .busy, .done,
    .mem_valid, .mem_ready, .mem_write, .mem_addr, .mem_wdata, .mem_rdata,
    .rf_raddr, .rf_rdata, .rf_we, .rf_waddr, .rf_wdata, .sp_we, .sp_wdata
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: drives ready, pops scoreboard on each handshake
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      mem_ready = mem_valid && (!stall || (cyc % 3 == 0));
      #1;
      if (exp_done) chk(done == 1'b1, "R8", "done after last transfer", 32'(done), 1);
      else if (done && !empty_expect) chk(0, "R8", "unexpected done", 32'(done), 0);
      if (exp_done) chk(busy == 1'b0, "R8", "busy with done", 32'(busy), 0);
      exp_done = 0;
      if (was_stalled)
        chk(mem_valid && mem_addr == stall_addr, "R7", "request held", mem_addr, stall_addr);
      was_stalled = mem_valid && !mem_ready;
      stall_addr  = mem_addr;
      if (mem_valid && mem_ready) begin
        if (q.size() == 0) begin
          chk(0, "R2", "unexpected request", mem_addr, 0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(mem_write == it.wr, "R1", "direction", 32'(mem_write), 32'(it.wr));
          chk(mem_addr == it.addr, it.wr ? "R4" : "R3", "address", mem_addr, it.addr);
          if (it.wr) begin
            chk(rf_raddr == it.r, "R5", "store register order", 32'(rf_raddr), 32'(it.r));
            chk(mem_wdata == it.data, "R4", "store data", mem_wdata, it.data);
            mem[mem_addr[7:2]] = mem_wdata;
          end else begin
            chk(rf_we && rf_waddr == it.r, "R5", "load register order", 32'(rf_waddr), 32'(it.r));
            chk(rf_wdata == it.data, "R3", "load data", rf_wdata, it.data);
            if (it.r == 4'hF) chk(!sp_we, "R10", "sp write suppressed", 32'(sp_we), 0);
          end
          if (rf_we) regs[rf_waddr] = rf_wdata;
          if (sp_we) regs[15] = sp_wdata;
          if (q.size() == 0) exp_done = 1;
        end
      end
    end
  end

  // driver: pushes expected transfers, issues the start, waits for the end
  task automatic run_op(input logic [7:0] op, input logic [7:0] lst, input bit poke);
    logic [31:0] sp;
    logic [31:0] exp_sp;
    bit          bank;
    sp = regs[15];
    bank = op[0];
    exp_sp = sp;
    if (op[1]) begin
      for (int i = 7; i >= 0; i--) if (lst[i]) begin
        item_t it;
        sp = sp - 4;
        it.wr = 1; it.addr = sp; it.r = {bank, 3'(i)}; it.data = regs[it.r];
        q.push_back(it);
      end
      exp_sp = sp;
    end else begin
      for (int i = 0; i < 8; i++) if (lst[i]) begin
        item_t it;
        it.wr = 0; it.addr = sp; it.r = {bank, 3'(i)}; it.data = mem[sp[7:2]];
        q.push_back(it);
        sp = sp + 4;
        exp_sp = (it.r == 4'hF) ? it.data : sp;
      end
    end
    @(negedge clk);
    start = 1; opcode = op; reglist = lst;
    empty_expect = (lst == 0);
    @(negedge clk);
    start = 0;
    if (lst == 0) begin
      #2;
      chk(done == 1'b1, "R6", "empty list done", 32'(done), 1);
      chk(!busy && !mem_valid, "R6", "empty list no traffic", 32'(mem_valid), 0);
      @(negedge clk);
      empty_expect = 0;
    end else begin
      if (poke) begin
        @(negedge clk);
        start = 1; opcode = 8'h8C; reglist = 8'h01;
        @(negedge clk);
        start = 0;
        chk(busy == 1'b1, "R9", "busy during ignored start", 32'(busy), 1);
      end
      do @(negedge clk); while (busy || q.size() != 0);
      repeat (2) @(negedge clk);
    end
    chk(regs[15] == exp_sp, op[1] ? "R4" : "R3", "final stack pointer", regs[15], exp_sp);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "R8", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    logic [31:0] saved [8];
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + 32'(i) * 32'h111;
    regs[15] = 32'h80;
    for (int i = 0; i < 64; i++) mem[i] = 32'hA000_0000 | 32'(i);
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_valid, "R8", "reset state", {busy, done, mem_valid}, 0);
    rst_n = 1;
    @(negedge clk);

    // R4 R5: sparse store, lower bank, no stalls
    for (int i = 0; i < 8; i++) saved[i] = regs[i];
    run_op(8'h8E, 8'hA5, 0);
    // R3 R5: clear and reload the same list, restore check
    for (int i = 0; i < 8; i++) regs[i] = '0;
    run_op(8'h8C, 8'hA5, 0);
    for (int i = 0; i < 8; i++)
      if (8'hA5 & (8'h01 << i))
        chk(regs[i] == saved[i], "R5", "round trip restore", regs[i], saved[i]);

    // R7: stalled full store of upper bank, R15 first
    stall = 1;
    run_op(8'h8F, 8'hFF, 0);
    run_op(8'h8D, 8'h7F, 0);
    // R10: load only R15 from a patched word
    mem[regs[15][7:2]] = 32'h40;
    run_op(8'h8D, 8'h80, 0);
    chk(regs[15] == 32'h40, "R10", "R15 takes loaded word", regs[15], 32'h40);
    regs[15] = 32'h80;

    // R6: empty list
    run_op(8'h8E, 8'h00, 0);

    // R1: illegal opcode ignored
    @(negedge clk);
    start = 1; opcode = 8'h8B; reglist = 8'hFF;
    @(negedge clk);
    start = 0;
    repeat (3) begin
      chk(!busy && !mem_valid, "R1", "illegal opcode ignored", 32'(busy), 0);
      @(negedge clk);
    end

    // R9: start during a stalled store is ignored
    run_op(8'h8E, 8'h03, 1);

    stall = 0;
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R2", "scoreboard drained", 32'(q.size()), 0);
    summary();
  end
endmodule